// File: doc/BRIEF.md
# Serial Configuration Loader for a Cell Column

This block fills the configuration registers of one column of reconfigurable array cells. The cells are joined in a serial chain. Each cell keeps three configuration bits. On every rising edge of a shared strobe, a cell takes a new bit into its least significant position, shifts its contents upward, and hands its top bit to the cell below it. Software writes one character per cell, numbered from the top cell (index 0) to the bottom cell, into a small symbol table. It then pulses `start`. The block turns each character into a 3-bit code and clocks the codes into the chain, one bit per strobe. It keeps the column reset asserted for the whole load and raises `done` once it has finished.

The loader sends the bottom cell's code first, with the most significant bit first inside each cell. After 3·N strobes every cell therefore holds exactly its own code. The strobe high and low times are taken from two inputs when the load starts. A value of zero is treated as one clock.

The sequencer is a five-state machine:
- **IDLE**: waits. It leaves IDLE on an accepted `start` (transition *launch*).
- **SETUP**: asserts the chain reset and presents the first bit for one clock. It always moves to HIGH (*arm*).
- **HIGH**: holds the strobe high. When the high time has expired it moves to LOW (*next bit*). After the final bit it moves to TAIL instead (*finish*).
- **LOW**: holds the strobe low with the next bit already on the data line. When the low time has expired it moves back to HIGH (*pulse*).
- **TAIL**: holds the chain reset for one more clock. It then returns to IDLE (*release*) and sets `done`.

Top module: `cfg_chain_loader`

## Requirements
- R1: Characters encode as follows: '.'→000, '+'→001, '-'→010, '|'→011, '1'→100, '0'→101, 'Y'→110, 'N'→111. The 8-bit ASCII value is written on `sym_char` at cell index `sym_addr` while `sym_we` is high.
- R2: Any other character is loaded as 000. It also sets `sym_err` at launch, and `sym_err` stays set until the next accepted start.
- R3: One load produces exactly 3·N strobe rising edges. The bits are ordered bottom cell first and MSB first, so that afterwards cell i of the chain holds the code of symbol i.
- R4: `chain_reset` is high at every strobe rising edge. It stays high for exactly one clock after the last strobe falls and then drops in the same cycle that `done` rises. An accepted start clears `done`.
- R5: Each strobe high phase lasts max(hi_cycles,1) clocks. Each low phase between two strobes lasts max(lo_cycles,1) clocks. Both values are captured at launch.
- R6: `chain_bit` does not change in the clock before any strobe rising edge.
- R7: A `start` pulse while `busy` is high is ignored. This includes the final TAIL cycle.
- R8: A symbol write while `busy` is high leaves the table unchanged.
- R9: After reset, `chain_strobe`, `chain_reset`, `busy`, `done` and `sym_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_we | input | 1 | Symbol table write enable |
| sym_addr | input | $clog2(N_CELLS) | Cell index, 0 = top |
| sym_char | input | 8 | ASCII configuration character |
| hi_cycles | input | TIME_W | Strobe high time in clocks |
| lo_cycles | input | TIME_W | Strobe low time in clocks |
| start | input | 1 | Single-cycle load request |
| chain_bit | output | 1 | Serial data into the top cell |
| chain_strobe | output | 1 | Configuration strobe |
| chain_reset | output | 1 | Column reset, held during loading |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load completed |
| sym_err | output | 1 | Sticky undefined-symbol flag |

## Verification
Two functions can fall in the same clock. The first pair is the release of the column reset on the TAIL→IDLE step and a fresh `start` request. The bench watches the strobe count at the ports, pulses `start` in exactly the cycle after the last strobe falls, and then requires `done` to rise while `busy` and `chain_reset` stay low with no new strobes. The second pair is a strobe sequence in progress together with a write into the table. The bench writes a different character to cell 0, which is shifted out last, together with a mid-load `start`. The behavioural chain model must still end with the original code in cell 0.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } ld_state_e;

    // returns {undefined, code}
    function automatic logic [CODE_W:0] encode_sym(input logic [7:0] ch);
        logic [CODE_W:0] r;
        case (ch)
            8'h2E:   r = 4'b0_000;
            8'h2B:   r = 4'b0_001;
            8'h2D:   r = 4'b0_010;
            8'h7C:   r = 4'b0_011;
            8'h31:   r = 4'b0_100;
            8'h30:   r = 4'b0_101;
            8'h59:   r = 4'b0_110;
            8'h4E:   r = 4'b0_111;
            default: r = 4'b1_000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfgld_symtab.sv
module cfgld_symtab
    import cfgld_pkg::*;
#(
    parameter int N_CELLS = 8,
    parameter int AW      = $clog2(N_CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [7:0]        wr_char,
    input  logic              lock,
    input  logic [AW-1:0]     rd_idx,
    output logic [CODE_W-1:0] rd_code,
    output logic              any_bad
);

    localparam int FLAT_W = N_CELLS * CODE_W;

    logic [FLAT_W-1:0]  code_flat;
    logic [N_CELLS-1:0] bad_vec;
    logic [CODE_W:0]    enc;

    assign enc = encode_sym(wr_char);

    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_flat[g*CODE_W +: CODE_W] <= '0;
                bad_vec[g]                    <= 1'b0;
            end else if (wr_en && !lock && wr_idx == AW'(g)) begin
                code_flat[g*CODE_W +: CODE_W] <= enc[CODE_W-1:0];
                bad_vec[g]                    <= enc[CODE_W];
            end
        end
    end

    assign rd_code = code_flat[rd_idx*CODE_W +: CODE_W];
    assign any_bad = |bad_vec;

    assert_locked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock) |=> ($stable(code_flat) && $stable(bad_vec)));

endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int N_CELLS = 8,
    parameter int TIME_W  = 8,
    parameter int AW      = $clog2(N_CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TIME_W-1:0] hi_cycles,
    input  logic [TIME_W-1:0] lo_cycles,
    input  logic [CODE_W-1:0] cur_code,
    input  logic              any_bad,
    output logic [AW-1:0]     rd_idx,
    output logic              chain_bit,
    output logic              chain_strobe,
    output logic              chain_reset,
    output logic              busy,
    output logic              done,
    output logic              sym_err
);

    localparam logic [AW-1:0] LAST_CELL = AW'(N_CELLS - 1);
    localparam logic [1:0]    TOP_BIT   = 2'(CODE_W - 1);

    ld_state_e         state_q;
    logic [TIME_W-1:0] cnt_q, hi_q, lo_q;
    logic [AW-1:0]     cell_q;
    logic [1:0]        bit_q;
    logic              done_q, err_q;
    logic              last_bit;

    assign last_bit = (cell_q == '0) && (bit_q == 2'd0);

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            cell_q  <= '0;
            bit_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    hi_q    <= (hi_cycles == '0) ? TIME_W'(1) : hi_cycles;
                    lo_q    <= (lo_cycles == '0) ? TIME_W'(1) : lo_cycles;
                    cell_q  <= LAST_CELL;
                    bit_q   <= TOP_BIT;
                    err_q   <= any_bad;
                    done_q  <= 1'b0;
                    state_q <= ST_SETUP;
                end
                ST_SETUP: begin
                    cnt_q   <= TIME_W'(1);
                    state_q <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (cnt_q == hi_q) begin
                        cnt_q <= TIME_W'(1);
                        if (last_bit) begin
                            state_q <= ST_TAIL;
                        end else begin
                            if (bit_q == 2'd0) begin
                                bit_q  <= TOP_BIT;
                                cell_q <= cell_q - AW'(1);
                            end else begin
                                bit_q <= bit_q - 2'd1;
                            end
                            state_q <= ST_LOW;
                        end
                    end else begin
                        cnt_q <= cnt_q + TIME_W'(1);
                    end
                end
                ST_LOW: begin
                    if (cnt_q == lo_q) begin
                        cnt_q   <= TIME_W'(1);
                        state_q <= ST_HIGH;
                    end else begin
                        cnt_q <= cnt_q + TIME_W'(1);
                    end
                end
                ST_TAIL: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        chain_strobe = (state_q == ST_HIGH);
        chain_reset  = (state_q != ST_IDLE);
        busy         = (state_q != ST_IDLE);
        chain_bit    = (state_q != ST_IDLE) ? cur_code[bit_q] : 1'b0;
        rd_idx       = cell_q;
        done         = done_q;
        sym_err      = err_q;
    end

    assert_strobe_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chain_strobe |-> chain_reset);

    assert_release_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(state_q) == ST_TAIL && !chain_reset));

    assert_bit_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_strobe) |-> $stable(chain_bit));

    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=> (state_q != ST_SETUP));

    assert_high_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chain_strobe |-> (cnt_q <= hi_q && cnt_q != '0));

endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader
    import cfgld_pkg::*;
#(
    parameter int N_CELLS = 8,
    parameter int TIME_W  = 8,
    parameter int AW      = $clog2(N_CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_we,
    input  logic [AW-1:0]     sym_addr,
    input  logic [7:0]        sym_char,
    input  logic [TIME_W-1:0] hi_cycles,
    input  logic [TIME_W-1:0] lo_cycles,
    input  logic              start,
    output logic              chain_bit,
    output logic              chain_strobe,
    output logic              chain_reset,
    output logic              busy,
    output logic              done,
    output logic              sym_err
);

    logic [AW-1:0]     rd_idx;
    logic [CODE_W-1:0] cur_code;
    logic              any_bad;

    cfgld_symtab #(.N_CELLS(N_CELLS), .AW(AW)) u_symtab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sym_we),
        .wr_idx  (sym_addr),
        .wr_char (sym_char),
        .lock    (busy),
        .rd_idx  (rd_idx),
        .rd_code (cur_code),
        .any_bad (any_bad)
    );

    cfgld_seq #(.N_CELLS(N_CELLS), .TIME_W(TIME_W), .AW(AW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .hi_cycles    (hi_cycles),
        .lo_cycles    (lo_cycles),
        .cur_code     (cur_code),
        .any_bad      (any_bad),
        .rd_idx       (rd_idx),
        .chain_bit    (chain_bit),
        .chain_strobe (chain_strobe),
        .chain_reset  (chain_reset),
        .busy         (busy),
        .done         (done),
        .sym_err      (sym_err)
    );

endmodule

// File: tb/cfg_chain_loader_tb.sv
`timescale 1ns/1ps
module cfg_chain_loader_tb;

    localparam int N  = 8;
    localparam int TW = 8;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sym_we = 1'b0;
    logic [AW-1:0] sym_addr = '0;
    logic [7:0]    sym_char = '0;
    logic [TW-1:0] hi_cycles = '0, lo_cycles = '0;
    logic          start = 1'b0;
    logic          chain_bit, chain_strobe, chain_reset, busy, done, sym_err;

    always #2.5 clk = ~clk;

    cfg_chain_loader #(.N_CELLS(N), .TIME_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sym_we(sym_we), .sym_addr(sym_addr),
        .sym_char(sym_char), .hi_cycles(hi_cycles), .lo_cycles(lo_cycles),
        .start(start), .chain_bit(chain_bit), .chain_strobe(chain_strobe),
        .chain_reset(chain_reset), .busy(busy), .done(done), .sym_err(sym_err)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    logic [2:0] exp_q[$];
    int  exp_hi = 1, exp_lo = 1;
    bit  exp_err = 0;
    logic [2:0] model [N];
    int  nstr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_code(input byte c);
        case (c)
            "+": return 4'h1;  "-": return 4'h2;  "|": return 4'h3;
            "1": return 4'h4;  "0": return 4'h5;  "Y": return 4'h6;
            "N": return 4'h7;  ".": return 4'h0;
            default: return 4'h8;
        endcase
    endfunction

    // monitor: behavioural cell chain plus timing checks
    logic prev_s = 0, prev_b = 0, prev_r = 0, prev_d = 0;
    int hi_len = 0, lo_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (chain_strobe && !prev_s) begin
                nstr++;
                chk(prev_b == chain_bit, "R6 bit stable before strobe", chain_bit, prev_b);
                chk(chain_reset, "R4 reset high at strobe", chain_reset, 1);
                if (nstr > 1) chk(lo_len == exp_lo, "R5 low time", lo_len, exp_lo);
                for (int i = N - 1; i > 0; i--) model[i] = {model[i][1:0], model[i-1][2]};
                model[0] = {model[0][1:0], chain_bit};
                hi_len = 1;
            end else if (chain_strobe) begin
                hi_len++;
            end
            if (!chain_strobe && prev_s) begin
                chk(hi_len == exp_hi, "R5 high time", hi_len, exp_hi);
                lo_len = 1;
            end else if (!chain_strobe && busy) begin
                lo_len++;
            end
            if (done && !prev_d) begin
                chk(nstr == 3 * N, "R3 strobe count", nstr, 3 * N);
                chk(prev_r && !prev_s && !chain_reset, "R4 release one clock after last strobe",
                    chain_reset, 0);
                chk(sym_err == exp_err, "R2 error flag", sym_err, exp_err);
                for (int i = 0; i < N; i++) begin
                    logic [2:0] e;
                    e = exp_q.pop_front();
                    chk(model[i] == e, "R3/R1 cell code", model[i], e);
                end
                nstr = 0;
            end
        end
        prev_s = chain_strobe; prev_b = chain_bit; prev_r = chain_reset; prev_d = done;
    end

    // driver: mode 0 plain, 1 write+start mid-load, 2 start in final cycle
    task automatic load_col(input string s, input int hi, input int lo, input int mode);
        bit bad = 0;
        for (int i = 0; i < N; i++) begin
            logic [3:0] r;
            @(negedge clk);
            sym_we = 1; sym_addr = AW'(i); sym_char = s[i];
            r = ref_code(s[i]);
            exp_q.push_back(r[2:0]);
            bad |= r[3];
        end
        @(negedge clk);
        sym_we = 0;
        exp_err = bad;
        exp_hi = (hi == 0) ? 1 : hi;
        exp_lo = (lo == 0) ? 1 : lo;
        hi_cycles = TW'(hi); lo_cycles = TW'(lo);
        start = 1;
        @(negedge clk);
        start = 0;
        #1;
        chk(busy && !done, "R4 start clears done", done, 0);
        if (mode == 1) begin
            while (nstr < 4) begin @(negedge clk); #1; end
            sym_we = 1; sym_addr = '0; sym_char = "N"; start = 1;  // R7 R8
            @(negedge clk);
            sym_we = 0; start = 0;
        end
        if (mode == 2) begin
            do begin @(negedge clk); #1; end while (!(nstr == 3 * N && !chain_strobe));
            start = 1;  // R7: final busy cycle
            @(negedge clk);
            start = 0;
        end
        wait (done);
        @(negedge clk);
        if (mode == 2) begin
            for (int k = 0; k < 4; k++) begin
                #1;
                chk(!busy && !chain_reset && !chain_strobe, "R7 start in final cycle ignored",
                    busy, 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk({chain_strobe, chain_reset, busy, done, sym_err} == 5'b0, "R9 reset state",
            {chain_strobe, chain_reset, busy, done, sym_err}, 0);
        rst_n = 1;
        @(negedge clk); #1;
        chk({chain_strobe, chain_reset, busy, done, sym_err} == 5'b0, "R9 idle after reset",
            {chain_strobe, chain_reset, busy, done, sym_err}, 0);
        load_col("+-|10YN.", 1, 1, 0);
        load_col("xY..N0?|", 3, 2, 0);   // R2 undefined symbols
        load_col("|||+++--", 0, 0, 0);   // R5 zero clamps to one
        load_col("10YN+.-|", 2, 4, 1);   // R7 R8 mid-load start and write
        load_col("NNNNYYYY", 1, 3, 2);   // R7 start in final cycle
        chk(exp_q.size() == 0, "R3 all loads observed", exp_q.size(), 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule